// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

A single 16-bit timer channel. It counts up or down from a clock that can be divided by a power of two. The count wraps either at a programmed interval or across the full 16-bit range. Three compare values each raise a flag of their own. The channel records every wrap and every compare hit in a sticky cause vector and also shows the live count value. An upstream bus block owns register decoding and clear-on-read. It drives the prescale word, the interval and the compare values as levels, writes the counter-control word through a strobe, and pulses a clear input when software reads the cause vector.

The control word uses these bits: bit 0 stops counting, bit 1 selects interval mode, bit 2 selects counting down, bit 3 enables compare flags, and bit 4 is a write-only strobe that zeroes the count. Bit 5 is stored and read back but has no function here. The clock-configuration word uses bit 0 to enable the divider and bits 4:1 to hold the divide exponent N.

Top module: `ptimer_chan`

## Requirements
- R1: After reset the control readback is 0x21 (channel stopped), the count is 0 and the cause vector is 0.
- R2: A control write stores bits 5,3,2,1,0 and always reads back bit 4 as 0. When written bit 4 is 1, the count becomes 0 on the write edge.
- R3: With clock-config bit 0 set and bits 4:1 equal to N, the count steps once every 2^(N+1) clocks. With bit 0 clear it steps on every clock. The divider restarts from zero on a control write, on any change of the clock-config word, and while counting is stopped.
- R4: In interval mode (control bit 1), counting up runs from 0 to the interval value inclusive and then goes to 0. That wrap sets cause bit 0.
- R5: In free-running mode, the count wraps from 0xFFFF to 0 when counting up, and that wrap sets cause bit 4.
- R6: When counting down (control bit 2), a step from 0 loads the top of the range (interval value or 0xFFFF) and sets the wrap cause bit for the active mode (bit 0 in interval mode, bit 4 otherwise).
- R7: With control bit 3 set, a step that lands on compare value k (k=1..3, value k at bits 16k-1:16k-16 of the compare bus) sets cause bit k. A compare value above the active range never fires. With bit 3 clear, no compare flag is set.
- R8: Cause bits are sticky. A clear pulse zeroes them, except that a bit being set on the same edge as the clear stays set. Cause bit 5 always reads 0.
- R9: While control bit 0 is set, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_cfg_i | input | 6 | Bit 0 enables the divider, bits 4:1 hold the exponent N, bit 5 has no function |
| ctrl_wr_i | input | 1 | Write strobe for the control word |
| ctrl_wdata_i | input | 6 | Control word to write |
| interval_i | input | 16 | Interval (top count) value |
| match_i | input | 48 | Three compare values, value 1 in the low bits |
| cause_clr_i | input | 1 | Clears the cause vector |
| ctrl_o | output | 6 | Stored control word |
| count_o | output | 16 | Live count value |
| cause_o | output | 6 | Sticky cause vector |

## Verification
The assertions assume the interval and compare values change only while counting is stopped. They also assume the clock-config word stays steady between control writes, so the count never sits above a freshly lowered interval. The directed tasks follow these rules: every test first stops the channel, then loads the configuration and clears the causes, and only after that starts counting with a reset-strobe write. The window checks on counting steps are limited to the undivided clock, so that each check covers exactly one cycle.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int CTRL_W  = 6;
  localparam int CFG_W   = 6;
  localparam int C_STOP  = 0;
  localparam int C_IVL   = 1;
  localparam int C_DOWN  = 2;
  localparam int C_MEN   = 3;
  localparam int C_ZERO  = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST_VAL = 6'h21;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic            en_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int DIV_W = 1 << PS_W;

  logic [DIV_W-1:0] div_q, lim;

  // terminal value 2^(sel+1)-1: ones in the low sel+1 bits
  always_comb begin
    for (int i = 0; i < DIV_W; i++) lim[i] = (i <= int'(sel_i));
  end

  assign tick_o = run_i && (!en_i || (div_q == lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           div_q <= '0;
    else if (restart_i || !run_i || !en_i) div_q <= '0;
    else if (div_q == lim)                 div_q <= '0;
    else                                   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       zero_i,
  input  logic                       down_i,
  input  logic                       ivl_i,
  input  logic                       men_i,
  input  logic [CNT_W-1:0]           interval_i,
  input  logic [NUM_MATCH*CNT_W-1:0] match_i,
  output logic [CNT_W-1:0]           count_o,
  output logic                       wrap_o,
  output logic [NUM_MATCH-1:0]       hit_o
);
  logic [CNT_W-1:0] cnt_q, nxt, top;
  logic             wrap;

  assign top = ivl_i ? interval_i : {CNT_W{1'b1}};

  always_comb begin
    nxt  = cnt_q;
    wrap = 1'b0;
    if (down_i) begin
      if (cnt_q == '0) begin
        nxt  = top;
        wrap = 1'b1;
      end else if (cnt_q > top) begin
        nxt = top;
      end else begin
        nxt = cnt_q - 1'b1;
      end
    end else begin
      if (cnt_q >= top) begin
        nxt  = '0;
        wrap = 1'b1;
      end else begin
        nxt = cnt_q + 1'b1;
      end
    end
  end

  assign wrap_o = tick_i && wrap && !zero_i;

  // next value never exceeds top, so out-of-range compares cannot hit
  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_hit
    assign hit_o[k] = tick_i && men_i && !zero_i &&
                      (nxt == match_i[k*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_cause.sv
module tmr_cause #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (clr_i ? '0 : q) | set_i;
  end

  assign cause_o = q;
endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
  import ptimer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 3,
  parameter int PS_W      = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CFG_W-1:0]           clk_cfg_i,
  input  logic                       ctrl_wr_i,
  input  logic [CTRL_W-1:0]          ctrl_wdata_i,
  input  logic [CNT_W-1:0]           interval_i,
  input  logic [NUM_MATCH*CNT_W-1:0] match_i,
  input  logic                       cause_clr_i,
  output logic [CTRL_W-1:0]          ctrl_o,
  output logic [CNT_W-1:0]           count_o,
  output logic [NUM_MATCH+2:0]       cause_o
);
  localparam int CAUSE_W = NUM_MATCH + 3;
  localparam int Q_OVF   = NUM_MATCH + 1;

  logic [CTRL_W-1:0]    ctrl_q;
  logic [CFG_W-1:0]     cfg_q;
  logic                 tick, wrap, restart, zero;
  logic [NUM_MATCH-1:0] hit;
  logic [CAUSE_W-1:0]   set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST_VAL;
      cfg_q  <= '0;
    end else begin
      cfg_q <= clk_cfg_i;
      if (ctrl_wr_i) ctrl_q <= ctrl_wdata_i & ~(CTRL_W'(1) << C_ZERO);
    end
  end

  assign restart = ctrl_wr_i || (clk_cfg_i != cfg_q);
  assign zero    = ctrl_wr_i && ctrl_wdata_i[C_ZERO];

  tmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (!ctrl_q[C_STOP]),
    .restart_i (restart),
    .en_i      (clk_cfg_i[0]),
    .sel_i     (clk_cfg_i[PS_W:1]),
    .tick_o    (tick)
  );

  tmr_count #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .zero_i     (zero),
    .down_i     (ctrl_q[C_DOWN]),
    .ivl_i      (ctrl_q[C_IVL]),
    .men_i      (ctrl_q[C_MEN]),
    .interval_i (interval_i),
    .match_i    (match_i),
    .count_o    (count_o),
    .wrap_o     (wrap),
    .hit_o      (hit)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[0]     = wrap && ctrl_q[C_IVL];
    set_vec[Q_OVF] = wrap && !ctrl_q[C_IVL];
    for (int k = 0; k < NUM_MATCH; k++) set_vec[k+1] = hit[k];
  end

  tmr_cause #(.W(CAUSE_W)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (cause_clr_i),
    .cause_o (cause_o)
  );

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ptimer_chan_chk.sv
module ptimer_chan_chk #(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [5:0]                 clk_cfg_i,
  input logic                       ctrl_wr_i,
  input logic [5:0]                 ctrl_wdata_i,
  input logic [CNT_W-1:0]           interval_i,
  input logic [NUM_MATCH*CNT_W-1:0] match_i,
  input logic                       cause_clr_i,
  input logic [5:0]                 ctrl_o,
  input logic [CNT_W-1:0]           count_o,
  input logic [NUM_MATCH+2:0]       cause_o
);
  logic plain_run;
  assign plain_run = !ctrl_o[0] && !clk_cfg_i[0] && !ctrl_wr_i;

  p_strobe_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_wdata_i[4] |=> count_o == '0);

  p_bit4_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[4] == 1'b0);

  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_run && !ctrl_o[1] && !ctrl_o[2] |=> count_o == CNT_W'($past(count_o) + 1'b1));

  p_ivl_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_run && ctrl_o[1] && !ctrl_o[2] && count_o == interval_i
    |=> count_o == '0 && cause_o[0]);

  p_down_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_run && ctrl_o[2] && count_o == '0
    |=> count_o == ($past(ctrl_o[1]) ? $past(interval_i) : {CNT_W{1'b1}}));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_clr_i |=> ($past(cause_o) & ~cause_o) == '0);

  p_evt_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o[NUM_MATCH+2] == 1'b0);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] && !ctrl_wr_i |=> $stable(count_o));
endmodule

bind ptimer_chan ptimer_chan_chk #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_chk (.*);

// File: tb/ptimer_chan_bench.sv
module ptimer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  clk_cfg = '0;
  logic        ctrl_wr = 1'b0;
  logic [5:0]  ctrl_wd = '0;
  logic [15:0] interval = '0;
  logic [47:0] match = '0;
  logic        cause_clr = 1'b0;
  logic [5:0]  ctrl_o;
  logic [15:0] count_o;
  logic [5:0]  cause_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ptimer_chan u_ptimer_chan (
    .clk_i(clk), .rst_ni(rst_n), .clk_cfg_i(clk_cfg), .ctrl_wr_i(ctrl_wr),
    .ctrl_wdata_i(ctrl_wd), .interval_i(interval), .match_i(match),
    .cause_clr_i(cause_clr), .ctrl_o(ctrl_o), .count_o(count_o), .cause_o(cause_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    ctrl_wr = 1'b1; ctrl_wd = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    cause_clr = 1'b1;
    @(negedge clk);
    cause_clr = 1'b0;
  endtask

  // stop, load setup, clear causes
  task automatic setup(input logic [5:0] cfg, input logic [15:0] ivl, input logic [47:0] m);
    wr_ctrl(6'h01);
    clk_cfg = cfg; interval = ivl; match = m;
    step(1);
    pulse_clr();
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_o, 6'h21);
    chk("R1 count", count_o, 0);
    chk("R1 cause", cause_o, 0);
  endtask

  task automatic t_free_up();
    setup(6'h00, 16'd0, '0);
    wr_ctrl(6'h10);
    chk("R2 bit4 reads 0", ctrl_o, 6'h00);
    chk("R2 zeroed", count_o, 0);
    step(5);
    chk("R3 every clock", count_o, 5);
  endtask

  task automatic t_ivl_up();
    setup(6'h00, 16'd4, '0);
    wr_ctrl(6'h12);
    step(4);
    chk("R4 at top", count_o, 4);
    chk("R4 no cause yet", cause_o, 0);
    step(1);
    chk("R4 wrap count", count_o, 0);
    chk("R4 wrap cause", cause_o, 6'h01);
    step(3);
    chk("R8 sticky", cause_o, 6'h01);
    pulse_clr();
    chk("R8 cleared", cause_o, 0);
  endtask

  task automatic t_ivl_down();
    setup(6'h00, 16'd3, '0);
    wr_ctrl(6'h16);
    step(1);
    chk("R6 reload top", count_o, 3);
    chk("R6 ivl cause", cause_o, 6'h01);
    step(1);
    chk("R6 decrement", count_o, 2);
  endtask

  task automatic t_free_down();
    setup(6'h00, 16'd3, '0);
    wr_ctrl(6'h14);
    step(1);
    chk("R6 reload ffff", count_o, 16'hffff);
    chk("R6 ovf cause", cause_o, 6'h10);
  endtask

  task automatic t_free_wrap();
    setup(6'h00, 16'd0, '0);
    wr_ctrl(6'h10);
    step(65535);
    chk("R5 at ffff", count_o, 16'hffff);
    chk("R5 no cause", cause_o, 0);
    step(1);
    chk("R5 wrap count", count_o, 0);
    chk("R5 ovf cause", cause_o, 6'h10);
  endtask

  task automatic t_match();
    setup(6'h00, 16'd9, {16'd12, 16'd5, 16'd2});
    wr_ctrl(6'h1a);
    step(2);
    chk("R7 hit1", cause_o, 6'h02);
    step(3);
    chk("R7 hit2", cause_o, 6'h06);
    step(5);
    chk("R7 wrap count", count_o, 0);
    chk("R7 no hit above range", cause_o, 6'h07);
  endtask

  task automatic t_match_off();
    setup(6'h00, 16'd9, {16'd12, 16'd5, 16'd2});
    wr_ctrl(6'h12);
    step(10);
    chk("R7 compare disabled", cause_o, 6'h01);
  endtask

  task automatic t_prescale();
    setup(6'h03, 16'd0, '0);
    wr_ctrl(6'h10);
    step(3);
    chk("R3 div4 wait", count_o, 0);
    step(1);
    chk("R3 div4 first", count_o, 1);
    step(4);
    chk("R3 div4 second", count_o, 2);
    setup(6'h05, 16'd0, '0);
    wr_ctrl(6'h10);
    step(7);
    chk("R3 div8 wait", count_o, 0);
    step(1);
    chk("R3 div8 first", count_o, 1);
  endtask

  task automatic t_hold();
    logic [15:0] held;
    setup(6'h00, 16'd0, '0);
    wr_ctrl(6'h10);
    step(6);
    wr_ctrl(6'h3b);
    chk("R2 readback", ctrl_o, 6'h2b);
    chk("R2 zero on write", count_o, 0);
    wr_ctrl(6'h00);
    step(4);
    wr_ctrl(6'h01);
    held = count_o;
    step(10);
    chk("R9 held", count_o, held);
    chk("R9 nonzero", held, 5);
  endtask

  task automatic t_set_wins();
    setup(6'h00, 16'd1, '0);
    wr_ctrl(6'h12);
    step(1);
    chk("R8 pre", count_o, 1);
    pulse_clr();
    chk("R8 set wins count", count_o, 0);
    chk("R8 set wins cause", cause_o, 6'h01);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_free_up();
    t_ivl_up();
    t_ivl_down();
    t_free_down();
    t_match();
    t_match_off();
    t_prescale();
    t_hold();
    t_set_wins();
    t_free_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule